// File: doc/BRIEF.md
# Landing Pad Expectation Tracker

This block keeps the forward-edge control-flow state of an in-order core that retires at most one instruction per cycle. It holds a single flag that records whether the next retiring instruction must be a landing pad. An indirect jump arms the flag unless its source register is a return-address register. While the flag is armed, every retiring instruction is checked in the same cycle. Anything other than a base-length landing pad makes the block request a software-check fault with the landing-pad cause. The faulting instruction is then not allowed to retire, and the program counter does not advance.

Two saved copies of the flag, one for machine mode and one for supervisor mode, carry the state across traps. When a trap is taken, the live flag is written into the copy that belongs to the privilege the trap goes to, and the live flag is then cleared. A return from machine mode reloads the flag from the machine copy. A return from supervisor mode reloads it from the supervisor copy. When the enable input is low, the flag is forced off and no fault is ever raised. The core feeds the block decoded per-instruction flags and trap and return events. The block returns the fault request, its cause code, the program counter increment, and the three state bits.

Top module: `lpad_guard`

## Requirements
- R1: After reset, `elp_o`, `mpelp_o`, `spelp_o` and `fault_o` are 0, and `cause_o` is 0.
- R2: When an enabled, non-faulting instruction with `jalr_i`=1 retires (no trap or return event that cycle), `elp_o` becomes 1 on the next cycle. The exception is a source register index of 1, 5 or 7, which gives 0.
- R3: While `elp_o`=1 and `en_i`=1, a valid base-length instruction (`rvc_i`=0) raises `fault_o`=1 in the same cycle unless it is a landing pad (`auipc_i`=1 with `rd_i`=0). A faulting instruction leaves `elp_o` unchanged.
- R4: While `elp_o`=1 and `en_i`=1, every valid compressed instruction (`rvc_i`=1) raises `fault_o`=1, even if it is flagged as AUIPC with `rd_i`=0.
- R5: A valid base-length landing pad raises no fault and clears `elp_o` on the next cycle.
- R6: When `trap_i`=1, the current `elp_o` is copied into `mpelp_o` if `trap_priv_i`=2'b11, or into `spelp_o` if `trap_priv_i`=2'b01. The other saved bit is unchanged, and `elp_o` is 0 on the next cycle.
- R7: Without a trap, `mret_i`=1 loads `elp_o` from `mpelp_o`. Otherwise, `sret_i`=1 loads it from `spelp_o`. Both take effect on the next cycle, and a machine return wins over a supervisor return.
- R8: When `en_i`=0, `fault_o` is 0 and `elp_o` is 0 on the next cycle.
- R9: A trap in the same cycle as a retiring JALR saves the flag value from before the JALR, and the JALR does not arm the flag.
- R10: `pc_inc_o` is 2 for a valid, non-faulting compressed instruction and 4 for a valid, non-faulting base instruction. It is 0 on a fault or when no instruction is valid.
- R11: `cause_o` equals the landing-pad cause parameter (default 2) when `fault_o`=1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Landing-pad enforcement enable |
| valid_i | input | 1 | An instruction retires this cycle |
| rvc_i | input | 1 | Retiring instruction is compressed |
| jalr_i | input | 1 | Retiring instruction is an indirect jump or call |
| rs1_i | input | REG_W | Source register index of the jump |
| auipc_i | input | 1 | Retiring instruction is AUIPC |
| rd_i | input | REG_W | Destination register index |
| trap_i | input | 1 | Trap taken this cycle |
| trap_priv_i | input | 2 | Target privilege of the trap (11 machine, 01 supervisor) |
| mret_i | input | 1 | Machine trap return |
| sret_i | input | 1 | Supervisor trap return |
| fault_o | output | 1 | Landing-pad fault request |
| cause_o | output | CAUSE_W | Software-check cause code |
| pc_inc_o | output | 3 | Program counter increment |
| elp_o | output | 1 | Live expectation flag |
| mpelp_o | output | 1 | Flag saved on traps into machine mode |
| spelp_o | output | 1 | Flag saved on traps into supervisor mode |

## Verification
The bench targets four corner cases:
- A compressed instruction carrying landing-pad decode flags while the flag is armed. A design that checked only the opcode would let it through with no fault.
- A JALR retiring in the same cycle as a trap. A design that let the jump update win would save the wrong value or leave the flag armed in the handler.
- A trap to an unlisted privilege, and a supervisor return. A design that mixed up the save index would corrupt the wrong saved bit.
- A low enable while the flag is armed. A design that kept checking would raise faults and change the program counter increment with enforcement switched off.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   typedef enum logic {
      EXPECT_NONE = 1'b0,
      EXPECT_PAD  = 1'b1
   } expect_e;

   localparam logic [1:0] PRIV_MACHINE    = 2'b11;
   localparam logic [1:0] PRIV_SUPERVISOR = 2'b01;

   localparam logic [2:0] STEP_NONE = 3'd0;
   localparam logic [2:0] STEP_HALF = 3'd2;
   localparam logic [2:0] STEP_FULL = 3'd4;
endpackage

// File: rtl/lpg_decode.sv
module lpg_decode #(
   parameter int REG_W = 5
) (
   input  logic             auipc_i,
   input  logic             rvc_i,
   input  logic [REG_W-1:0] rs1_i,
   input  logic [REG_W-1:0] rd_i,
   output logic             link_src_o,
   output logic             pad_o
);
   localparam logic [REG_W-1:0] LINK_A = REG_W'(1);
   localparam logic [REG_W-1:0] LINK_B = REG_W'(5);
   localparam logic [REG_W-1:0] LINK_C = REG_W'(7);
   localparam logic [REG_W-1:0] ZERO_R = '0;

   always_comb begin
      link_src_o = (rs1_i == LINK_A) || (rs1_i == LINK_B) || (rs1_i == LINK_C);
      pad_o      = auipc_i && !rvc_i && (rd_i == ZERO_R);
   end
endmodule

// File: rtl/lpg_check.sv
module lpg_check
   import lpg_pkg::*;
#(
   parameter int CAUSE_W    = 6,
   parameter int LPAD_CAUSE = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               elp_i,
   input  logic               valid_i,
   input  logic               rvc_i,
   input  logic               pad_i,
   output logic               fault_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [2:0]         pc_inc_o,
   output logic               retire_ok_o
);
   localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(LPAD_CAUSE);

   logic armed;

   always_comb begin
      armed       = en_i && (expect_e'(elp_i) == EXPECT_PAD);
      fault_o     = valid_i && armed && (rvc_i || !pad_i);
      cause_o     = fault_o ? CAUSE_VAL : '0;
      retire_ok_o = valid_i && !fault_o;
      if (!retire_ok_o)  pc_inc_o = STEP_NONE;
      else if (rvc_i)    pc_inc_o = STEP_HALF;
      else               pc_inc_o = STEP_FULL;
   end

   // R8
   off_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> !fault_o);
   // R10
   fault_holds_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (pc_inc_o == STEP_NONE));
   // R4
   rvc_armed_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && rvc_i && en_i && elp_i) |-> fault_o);
endmodule

// File: rtl/lpg_state.sv
module lpg_state
   import lpg_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       en_i,
   input  logic       retire_ok_i,
   input  logic       jalr_i,
   input  logic       link_src_i,
   input  logic       pad_i,
   input  logic       trap_i,
   input  logic [1:0] trap_priv_i,
   input  logic       mret_i,
   input  logic       sret_i,
   output logic       elp_o,
   output logic       mpelp_o,
   output logic       spelp_o
);
   logic elp_q, elp_d;
   logic mp_q, mp_d;
   logic sp_cur;
   logic sret_eff;

   always_comb begin
      elp_d = elp_q;
      mp_d  = mp_q;
      if (trap_i) begin
         if (trap_priv_i == PRIV_MACHINE) mp_d = elp_q;
         elp_d = EXPECT_NONE;
      end else if (mret_i) begin
         elp_d = mp_q;
      end else if (sret_eff) begin
         elp_d = sp_cur;
      end else if (retire_ok_i) begin
         if (jalr_i)     elp_d = link_src_i ? EXPECT_NONE : EXPECT_PAD;
         else if (pad_i) elp_d = EXPECT_NONE;
      end
      if (!en_i) elp_d = EXPECT_NONE;
   end

   generate
      if (HAS_SMODE) begin : g_sup
         logic sp_q, sp_d;
         always_comb begin
            sp_d = sp_q;
            if (trap_i && (trap_priv_i == PRIV_SUPERVISOR)) sp_d = elp_q;
         end
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sp_q <= 1'b0;
            else         sp_q <= sp_d;
         end
         assign sp_cur   = sp_q;
         assign sret_eff = sret_i;
      end else begin : g_nosup
         logic unused_sret;
         assign unused_sret = sret_i;
         assign sp_cur      = 1'b0;
         assign sret_eff    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         elp_q <= EXPECT_NONE;
         mp_q  <= 1'b0;
      end else begin
         elp_q <= elp_d;
         mp_q  <= mp_d;
      end
   end

   assign elp_o   = elp_q;
   assign mpelp_o = mp_q;
   assign spelp_o = sp_cur;

   // R6
   trap_clears_elp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i |=> !elp_o);
   // R6
   trap_save_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_i && trap_priv_i == PRIV_MACHINE) |=> (mpelp_o == $past(elp_o)));
   // R6
   trap_s_keeps_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_i && trap_priv_i != PRIV_MACHINE) |=> $stable(mpelp_o));
   // R8
   disabled_elp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !elp_o);
   // R7
   mret_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !trap_i && mret_i) |=> (elp_o == $past(mpelp_o)));
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
   import lpg_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int CAUSE_W    = 6,
   parameter int LPAD_CAUSE = 2,
   parameter bit HAS_SMODE  = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               valid_i,
   input  logic               rvc_i,
   input  logic               jalr_i,
   input  logic [REG_W-1:0]   rs1_i,
   input  logic               auipc_i,
   input  logic [REG_W-1:0]   rd_i,
   input  logic               trap_i,
   input  logic [1:0]         trap_priv_i,
   input  logic               mret_i,
   input  logic               sret_i,
   output logic               fault_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [2:0]         pc_inc_o,
   output logic               elp_o,
   output logic               mpelp_o,
   output logic               spelp_o
);
   if (REG_W < 3) begin : g_bad_regw
      $error("REG_W must hold register index 7");
   end
   if (LPAD_CAUSE < 1 || LPAD_CAUSE >= (1 << CAUSE_W)) begin : g_bad_cause
      $error("LPAD_CAUSE must be nonzero and fit in CAUSE_W bits");
   end

   logic link_src, pad, retire_ok;

   lpg_decode #(.REG_W(REG_W)) u_dec (
      .auipc_i   (auipc_i),
      .rvc_i     (rvc_i),
      .rs1_i     (rs1_i),
      .rd_i      (rd_i),
      .link_src_o(link_src),
      .pad_o     (pad)
   );

   lpg_check #(.CAUSE_W(CAUSE_W), .LPAD_CAUSE(LPAD_CAUSE)) u_chk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .elp_i      (elp_o),
      .valid_i    (valid_i),
      .rvc_i      (rvc_i),
      .pad_i      (pad),
      .fault_o    (fault_o),
      .cause_o    (cause_o),
      .pc_inc_o   (pc_inc_o),
      .retire_ok_o(retire_ok)
   );

   lpg_state #(.HAS_SMODE(HAS_SMODE)) u_st (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .retire_ok_i(retire_ok),
      .jalr_i     (jalr_i),
      .link_src_i (link_src),
      .pad_i      (pad),
      .trap_i     (trap_i),
      .trap_priv_i(trap_priv_i),
      .mret_i     (mret_i),
      .sret_i     (sret_i),
      .elp_o      (elp_o),
      .mpelp_o    (mpelp_o),
      .spelp_o    (spelp_o)
   );

   // R9
   trap_beats_jalr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_i && valid_i && jalr_i) |=> !elp_o);
   // R2
   jalr_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && retire_ok && jalr_i && !link_src && !trap_i && !mret_i && !sret_i) |=> elp_o);
endmodule

// File: tb/tb_lpad_guard.sv
module tb_lpad_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       en, valid, rvc, jalr, auipc, trap, mret, sret;
   logic [4:0] rs1, rd;
   logic [1:0] tpriv;
   logic       fault, elp, mp, sp;
   logic [5:0] cause;
   logic [2:0] pcinc;

   lpad_guard dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(valid), .rvc_i(rvc),
      .jalr_i(jalr), .rs1_i(rs1), .auipc_i(auipc), .rd_i(rd), .trap_i(trap),
      .trap_priv_i(tpriv), .mret_i(mret), .sret_i(sret), .fault_o(fault),
      .cause_o(cause), .pc_inc_o(pcinc), .elp_o(elp), .mpelp_o(mp), .spelp_o(sp)
   );

   int    errors = 0;
   int    checks = 0;
   bit    m_elp = 0, m_mp = 0, m_sp = 0;
   string prev_tag = "R1";

   task automatic chk(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit exp_fault(bit e, bit v, bit c, bit a, logic [4:0] d);
      return e && v && m_elp && (c || !(a && d == 5'd0));
   endfunction

   function automatic int exp_inc(bit f, bit v, bit c);
      if (!v || f) return 0;
      return c ? 2 : 4;
   endfunction

   function automatic bit is_link(logic [4:0] r);
      return r == 5'd1 || r == 5'd5 || r == 5'd7;
   endfunction

   task automatic step(input bit e, input bit v, input bit c, input bit j, input logic [4:0] s1,
                       input bit a, input logic [4:0] d, input bit t, input logic [1:0] p,
                       input bit mr, input bit sr);
      bit    f;
      bit    n_elp;
      string tag;
      @(negedge clk);
      chk(elp, m_elp, prev_tag, "elp");
      chk(mp, m_mp, prev_tag, "mpelp");
      chk(sp, m_sp, prev_tag, "spelp");
      en = e; valid = v; rvc = c; jalr = j; rs1 = s1; auipc = a; rd = d;
      trap = t; tpriv = p; mret = mr; sret = sr;
      #1;
      f = exp_fault(e, v, c, a, d);
      tag = c ? "R4" : (e ? "R3" : "R8");
      chk(fault, f, tag, "fault");
      chk(cause, f ? 2 : 0, "R11", "cause");
      chk(pcinc, exp_inc(f, v, c), "R10", "pc_inc");
      n_elp = m_elp;
      if (t) begin
         if (p == 2'b11) m_mp = m_elp;
         else if (p == 2'b01) m_sp = m_elp;
         n_elp = 0;
         prev_tag = (v && j) ? "R9" : "R6";
      end else if (mr) begin
         n_elp = m_mp; prev_tag = "R7";
      end else if (sr) begin
         n_elp = m_sp; prev_tag = "R7";
      end else if (v && !f && j) begin
         n_elp = !is_link(s1); prev_tag = "R2";
      end else if (v && !f && a && !c && d == 0) begin
         n_elp = 0; prev_tag = "R5";
      end else prev_tag = "R3";
      if (!e) begin n_elp = 0; prev_tag = "R8"; end
      m_elp = n_elp;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20231127));
      {en, valid, rvc, jalr, auipc, trap, mret, sret} = '0;
      rs1 = 0; rd = 0; tpriv = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(elp, 0, "R1", "elp"); chk(mp, 0, "R1", "mpelp"); chk(sp, 0, "R1", "spelp");
      chk(fault, 0, "R1", "fault"); chk(cause, 0, "R1", "cause");
      rst_n = 1'b1;
      // R2 arm, R4 compressed pad-like faults, R3 plain faults, R5 pad clears
      step(1,1,0,1,5'd6,0,5'd3,0,2'b00,0,0);
      step(1,1,1,0,5'd0,1,5'd0,0,2'b00,0,0);
      step(1,1,0,0,5'd0,1,5'd4,0,2'b00,0,0);
      step(1,1,0,0,5'd0,1,5'd0,0,2'b00,0,0);
      // R2 link registers do not arm
      step(1,1,0,1,5'd5,0,5'd1,0,2'b00,0,0);
      step(1,1,0,1,5'd7,0,5'd1,0,2'b00,0,0);
      // R6 trap to S saves 1; R9 trap with JALR saves 0 to M
      step(1,1,0,1,5'd10,0,5'd1,0,2'b00,0,0);
      step(1,0,0,0,5'd0,0,5'd0,1,2'b01,0,0);
      step(1,1,0,1,5'd10,0,5'd1,1,2'b11,0,0);
      // R7 returns
      step(1,0,0,0,5'd0,0,5'd0,0,2'b00,0,1);
      step(1,0,0,0,5'd0,0,5'd0,0,2'b00,1,0);
      // R8 disabled while armed
      step(1,1,0,1,5'd12,0,5'd1,0,2'b00,0,0);
      step(0,1,0,0,5'd0,0,5'd9,0,2'b00,0,0);
      step(1,1,1,0,5'd0,0,5'd0,0,2'b00,0,0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k = $urandom % 8;
         logic [4:0] r1 = ($urandom % 3 == 0) ? 5'(($urandom % 3 == 0) ? 1 : 5) : 5'($urandom);
         step(($urandom % 20) != 0, ($urandom % 4) != 0, ($urandom % 5) == 0,
              k < 3, r1, k == 3 || k == 4,
              ($urandom % 2) ? 5'd0 : 5'($urandom),
              ($urandom % 12) == 0, 2'($urandom),
              ($urandom % 15) == 0, ($urandom % 15) == 0);
      end
      step(1,0,0,0,5'd0,0,5'd0,0,2'b00,0,0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule